// File: doc/BRIEF.md
# Unlock Command Detector for a Shadowed Nonvolatile Memory Bank

This block watches the write traffic of one bank of a RAM backed by a nonvolatile array. It looks for a fixed three-write unlock sequence. Every write of that sequence must be made while the active-low nonvolatile-enable qualifier is held low. The first two writes are fixed address/data keys. The third write goes to a fixed address, and its data byte is a command. Three command bytes are recognised. One requests an immediate store of the RAM contents into the nonvolatile array. One arms the automatic store on power loss. One disarms it. The block emits a one-cycle pulse for the recognised command and holds the resulting arm flag for the bank.

A write made with the qualifier high is an ordinary RAM write and does not disturb a sequence in progress. A qualified write that breaks the sequence sends the detector back to idle, unless that write is itself a valid first key, in which case a new sequence starts from it. The bank-select (upper address) value is captured at the first write and must be the same on the second and third writes. One instance serves one bank. Decoding the upper address, the array and the store timer belong to the surrounding logic.

Top module: `unlock_cmd_detector`

## Requirements
- R1: After reset the arm flag `autostore_on` is 1 (armed) and all three pulse outputs are 0.
- R2: Three qualified writes (`wr_en`=1 with `nv_en_n`=0) carrying data 0xAA at address 0x555, then 0x55 at 0x2AA, then 0x33 at 0x555, all with the same `bank_tag`, produce exactly one `store_req` pulse.
- R3: The same sequence ending in data 0xCC pulses `arm_pulse` and sets `autostore_on` to 1. Ending in 0xCD, it pulses `disarm_pulse` and clears `autostore_on` to 0. The flag changes at no other time.
- R4: Each command pulse is exactly one clock cycle wide, and at most one of the three pulse outputs is high in any cycle.
- R5: A write with `nv_en_n`=1 leaves the sequence state unchanged. A full key sequence made with `nv_en_n`=1 produces no pulse, and such writes interleaved in a qualified sequence do not break it.
- R6: A qualified write whose address or data does not match the expected step returns the detector to idle. No pulse follows, even if the remaining steps arrive afterwards.
- R7: A mismatching qualified write that is itself 0xAA at 0x555 is taken as a new first step, so the sequence can complete from it.
- R8: A third write to 0x555 with an unrecognised data byte produces no pulse, leaves `autostore_on` unchanged and returns to idle.
- R9: A second or third write whose `bank_tag` differs from the value captured at the first write aborts the sequence (R7 still applies to it).
- R10: Cycles with `wr_en`=0 leave the sequence state unchanged, so idle gaps between the steps are allowed.
- R11: The pulse and the flag update appear in the first cycle after the clock edge that samples the third write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One write is sampled on each rising edge where this is high |
| nv_en_n | input | 1 | Active-low nonvolatile-enable qualifier for the write |
| addr_lo | input | ADDR_W (11) | Low address bits of the write |
| wr_data | input | DATA_W (8) | Write data byte |
| bank_tag | input | TAG_W (2) | Upper address bits that select the bank |
| store_req | output | 1 | One-cycle request to copy RAM into the nonvolatile array |
| arm_pulse | output | 1 | One-cycle pulse: automatic store armed |
| disarm_pulse | output | 1 | One-cycle pulse: automatic store disarmed |
| autostore_on | output | 1 | Current arm flag for the automatic store |

## Verification
The only internal state is the step register, the captured bank tag and the arm flag. A fault in any of them shows at the ports only when a command byte would complete a sequence. A step register that is stuck, advances wrongly or fails to clear therefore appears as a missing or spurious pulse in the cycle after the third write, or up to two writes later if a sequence was left half-open. A fault in the arm flag shows directly and at once on `autostore_on`. For this reason each scenario ends with a command write and checks every pulse count and the flag.

// File: rtl/unlk_pkg.sv
package unlk_pkg;

   // progress through the unlock sequence
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GOT1 = 2'd1,
      ST_GOT2 = 2'd2
   } unlk_state_e;

   // decoded command byte
   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_STORE  = 2'd1,
      CMD_ARM    = 2'd2,
      CMD_DISARM = 2'd3
   } unlk_cmd_e;

   // which step patterns the current write matches
   typedef struct packed {
      logic step1;   // first key address and data
      logic step2;   // second key address and data
      logic step3;   // command address (data is the command)
   } unlk_match_t;

endpackage

// File: rtl/unlk_step_match.sv
module unlk_step_match
   import unlk_pkg::*;
#(
   parameter int unsigned ADDR_W     = 11,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned STEP1_ADDR = 'h555,
   parameter int unsigned STEP1_KEY  = 'hAA,
   parameter int unsigned STEP2_ADDR = 'h2AA,
   parameter int unsigned STEP2_KEY  = 'h55,
   parameter int unsigned CMD_ADDR   = 'h555
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output unlk_match_t       hit
);

   localparam logic [ADDR_W-1:0] A1 = ADDR_W'(STEP1_ADDR);
   localparam logic [ADDR_W-1:0] A2 = ADDR_W'(STEP2_ADDR);
   localparam logic [ADDR_W-1:0] A3 = ADDR_W'(CMD_ADDR);
   localparam logic [DATA_W-1:0] K1 = DATA_W'(STEP1_KEY);
   localparam logic [DATA_W-1:0] K2 = DATA_W'(STEP2_KEY);

   always_comb begin
      hit.step1 = (addr == A1) && (data == K1);
      hit.step2 = (addr == A2) && (data == K2);
      hit.step3 = (addr == A3);
   end

endmodule

// File: rtl/unlk_cmd_decode.sv
module unlk_cmd_decode
   import unlk_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CODE_STORE  = 'h33,
   parameter int unsigned CODE_ARM    = 'hCC,
   parameter int unsigned CODE_DISARM = 'hCD
) (
   input  logic [DATA_W-1:0] data,
   output unlk_cmd_e         cmd
);

   localparam logic [DATA_W-1:0] C_ST = DATA_W'(CODE_STORE);
   localparam logic [DATA_W-1:0] C_AR = DATA_W'(CODE_ARM);
   localparam logic [DATA_W-1:0] C_DA = DATA_W'(CODE_DISARM);

   always_comb begin
      if (data == C_ST)      cmd = CMD_STORE;
      else if (data == C_AR) cmd = CMD_ARM;
      else if (data == C_DA) cmd = CMD_DISARM;
      else                   cmd = CMD_NONE;
   end

endmodule

// File: rtl/unlk_seq_fsm.sv
module unlk_seq_fsm
   import unlk_pkg::*;
#(
   parameter int unsigned TAG_W     = 2,
   parameter bit          CHECK_TAG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             nv_en_n,
   input  logic [TAG_W-1:0] tag,
   input  unlk_match_t      hit,
   output logic             fire
);

   unlk_state_e      state_q, state_d;
   logic [TAG_W-1:0] tag_q, tag_d;
   logic             tag_ok;
   logic             wr_nv;

   assign wr_nv = wr_en && !nv_en_n;

   generate
      if (CHECK_TAG) begin : g_tag_chk
         assign tag_ok = (tag == tag_q);

         // R9
         tag_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_nv && state_q != ST_IDLE && tag != tag_q && !hit.step1)
               |=> (state_q == ST_IDLE));
      end else begin : g_tag_free
         assign tag_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      tag_d   = tag_q;
      fire    = 1'b0;
      if (wr_nv) begin
         unique case (state_q)
            ST_IDLE: begin
               if (hit.step1) begin
                  state_d = ST_GOT1;
                  tag_d   = tag;
               end
            end
            ST_GOT1: begin
               if (hit.step2 && tag_ok) begin
                  state_d = ST_GOT2;
               end else if (hit.step1) begin
                  state_d = ST_GOT1;
                  tag_d   = tag;
               end else begin
                  state_d = ST_IDLE;
               end
            end
            ST_GOT2: begin
               if (hit.step3 && tag_ok) begin
                  state_d = ST_IDLE;
                  fire    = 1'b1;
               end else if (hit.step1) begin
                  state_d = ST_GOT1;
                  tag_d   = tag;
               end else begin
                  state_d = ST_IDLE;
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tag_q   <= '0;
      end else begin
         state_q <= state_d;
         tag_q   <= tag_d;
      end
   end

   // R10
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(state_q));

   // R5
   ram_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && nv_en_n) |=> $stable(state_q));

   // R6
   mismatch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_nv && state_q == ST_GOT1 && !hit.step1 && !hit.step2) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/unlk_cmd_out.sv
module unlk_cmd_out
   import unlk_pkg::*;
#(
   parameter bit ARM_AT_RESET = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      fire,
   input  unlk_cmd_e cmd,
   output logic      store_req,
   output logic      arm_pulse,
   output logic      disarm_pulse,
   output logic      autostore_on
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store_req    <= 1'b0;
         arm_pulse    <= 1'b0;
         disarm_pulse <= 1'b0;
         autostore_on <= ARM_AT_RESET;
      end else begin
         store_req    <= fire && (cmd == CMD_STORE);
         arm_pulse    <= fire && (cmd == CMD_ARM);
         disarm_pulse <= fire && (cmd == CMD_DISARM);
         if (fire && cmd == CMD_ARM)         autostore_on <= 1'b1;
         else if (fire && cmd == CMD_DISARM) autostore_on <= 1'b0;
      end
   end

   // R4
   pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({store_req, arm_pulse, disarm_pulse}));

   // R4
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req || arm_pulse || disarm_pulse) |=> !(store_req || arm_pulse || disarm_pulse));

   // R3
   arm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_pulse |-> autostore_on);

   // R3
   disarm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disarm_pulse |-> !autostore_on);

   // R3
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(autostore_on) |-> (arm_pulse || disarm_pulse));

endmodule

// File: rtl/unlock_cmd_detector.sv
module unlock_cmd_detector
   import unlk_pkg::*;
#(
   parameter int unsigned ADDR_W       = 11,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned TAG_W        = 2,
   parameter int unsigned STEP1_ADDR   = 'h555,
   parameter int unsigned STEP1_KEY    = 'hAA,
   parameter int unsigned STEP2_ADDR   = 'h2AA,
   parameter int unsigned STEP2_KEY    = 'h55,
   parameter int unsigned CMD_ADDR     = 'h555,
   parameter int unsigned CODE_STORE   = 'h33,
   parameter int unsigned CODE_ARM     = 'hCC,
   parameter int unsigned CODE_DISARM  = 'hCD,
   parameter bit          CHECK_TAG    = 1'b1,
   parameter bit          ARM_AT_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              nv_en_n,
   input  logic [ADDR_W-1:0] addr_lo,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [TAG_W-1:0]  bank_tag,
   output logic              store_req,
   output logic              arm_pulse,
   output logic              disarm_pulse,
   output logic              autostore_on
);

   localparam longint unsigned ADDR_SPAN = 64'd1 << ADDR_W;
   localparam longint unsigned DATA_SPAN = 64'd1 << DATA_W;

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
         $error("ADDR_W must lie in 2..32");
      end
      if (DATA_W < 2 || DATA_W > 32) begin : g_bad_data_w
         $error("DATA_W must lie in 2..32");
      end
      if (TAG_W < 1) begin : g_bad_tag_w
         $error("TAG_W must be at least 1");
      end
      if (STEP1_ADDR >= ADDR_SPAN || STEP2_ADDR >= ADDR_SPAN || CMD_ADDR >= ADDR_SPAN) begin : g_bad_addr
         $error("a step address does not fit in ADDR_W");
      end
      if (STEP1_KEY >= DATA_SPAN || STEP2_KEY >= DATA_SPAN || CODE_STORE >= DATA_SPAN ||
          CODE_ARM >= DATA_SPAN || CODE_DISARM >= DATA_SPAN) begin : g_bad_data
         $error("a key or command code does not fit in DATA_W");
      end
      if (STEP1_ADDR == STEP2_ADDR) begin : g_bad_keys
         $error("the first two step addresses must differ");
      end
      if (CODE_STORE == CODE_ARM || CODE_STORE == CODE_DISARM || CODE_ARM == CODE_DISARM) begin : g_bad_codes
         $error("command codes must be distinct");
      end
   endgenerate

   unlk_match_t hit;
   unlk_cmd_e   cmd;
   logic        seq_fire;

   unlk_step_match #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .STEP1_ADDR (STEP1_ADDR),
      .STEP1_KEY  (STEP1_KEY),
      .STEP2_ADDR (STEP2_ADDR),
      .STEP2_KEY  (STEP2_KEY),
      .CMD_ADDR   (CMD_ADDR)
   ) u_match (
      .addr (addr_lo),
      .data (wr_data),
      .hit  (hit)
   );

   unlk_cmd_decode #(
      .DATA_W      (DATA_W),
      .CODE_STORE  (CODE_STORE),
      .CODE_ARM    (CODE_ARM),
      .CODE_DISARM (CODE_DISARM)
   ) u_decode (
      .data (wr_data),
      .cmd  (cmd)
   );

   unlk_seq_fsm #(
      .TAG_W     (TAG_W),
      .CHECK_TAG (CHECK_TAG)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .nv_en_n (nv_en_n),
      .tag     (bank_tag),
      .hit     (hit),
      .fire    (seq_fire)
   );

   unlk_cmd_out #(
      .ARM_AT_RESET (ARM_AT_RESET)
   ) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .fire         (seq_fire),
      .cmd          (cmd),
      .store_req    (store_req),
      .arm_pulse    (arm_pulse),
      .disarm_pulse (disarm_pulse),
      .autostore_on (autostore_on)
   );

   // R11
   pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req || arm_pulse || disarm_pulse) |-> $past(seq_fire));

   // R8
   unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_fire && cmd == CMD_NONE) |=> !(store_req || arm_pulse || disarm_pulse) && $stable(autostore_on));

endmodule

// File: tb/unlock_cmd_detector_test.sv
`timescale 1ns/1ps
module unlock_cmd_detector_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       nv_en_n = 1'b1;
   logic [10:0] addr_lo = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  bank_tag = '0;
   logic       store_req, arm_pulse, disarm_pulse, autostore_on;

   int checks = 0;
   int errors = 0;
   int n_store = 0, n_arm = 0, n_dis = 0;

   always #10 clk = ~clk;

   unlock_cmd_detector uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .nv_en_n      (nv_en_n),
      .addr_lo      (addr_lo),
      .wr_data      (wr_data),
      .bank_tag     (bank_tag),
      .store_req    (store_req),
      .arm_pulse    (arm_pulse),
      .disarm_pulse (disarm_pulse),
      .autostore_on (autostore_on)
   );

   // pulse counters sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         n_store += int'(store_req);
         n_arm   += int'(arm_pulse);
         n_dis   += int'(disarm_pulse);
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic nvn, input logic [10:0] a, input logic [7:0] d, input logic [1:0] t);
      @(negedge clk);
      wr_en = 1'b1; nv_en_n = nvn; addr_lo = a; wr_data = d; bank_tag = t;
      @(negedge clk);
      wr_en = 1'b0; nv_en_n = 1'b1;
   endtask

   task automatic nvw(input logic [10:0] a, input logic [7:0] d, input logic [1:0] t);
      wr(1'b0, a, d, t);
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   task automatic t_reset();
      chk("R1", "flag after reset", int'(autostore_on), 1);
      chk("R1", "pulses after reset", int'({store_req, arm_pulse, disarm_pulse}), 0);
   endtask

   task automatic t_store();
      int s0 = n_store, a0 = n_arm, d0 = n_dis;
      nvw(11'h555, 8'hAA, 2'd1);
      nvw(11'h2AA, 8'h55, 2'd1);
      nvw(11'h555, 8'h33, 2'd1);
      chk("R11", "store_req in cycle after third write", int'(store_req), 1);
      chk("R4", "other pulses with store", int'({arm_pulse, disarm_pulse}), 0);
      @(negedge clk);
      chk("R4", "store_req one cycle wide", int'(store_req), 0);
      settle();
      chk("R2", "store pulse count", n_store - s0, 1);
      chk("R2", "no arm/disarm on store", (n_arm - a0) + (n_dis - d0), 0);
      chk("R3", "flag unchanged by store", int'(autostore_on), 1);
   endtask

   task automatic t_disarm_arm();
      int a0 = n_arm, d0 = n_dis;
      nvw(11'h555, 8'hAA, 2'd0);
      nvw(11'h2AA, 8'h55, 2'd0);
      nvw(11'h555, 8'hCD, 2'd0);
      chk("R11", "disarm pulse and flag in next cycle", int'({disarm_pulse, autostore_on}), 2);
      settle();
      chk("R3", "disarm pulse count", n_dis - d0, 1);
      chk("R3", "flag cleared", int'(autostore_on), 0);
      nvw(11'h555, 8'hAA, 2'd2);
      nvw(11'h2AA, 8'h55, 2'd2);
      nvw(11'h555, 8'hCC, 2'd2);
      chk("R11", "arm pulse and flag in next cycle", int'({arm_pulse, autostore_on}), 3);
      settle();
      chk("R3", "arm pulse count", n_arm - a0, 1);
      chk("R3", "flag set", int'(autostore_on), 1);
   endtask

   task automatic t_ram_writes();
      int s0 = n_store;
      // whole sequence as plain RAM writes
      wr(1'b1, 11'h555, 8'hAA, 2'd0);
      wr(1'b1, 11'h2AA, 8'h55, 2'd0);
      wr(1'b1, 11'h555, 8'h33, 2'd0);
      settle();
      chk("R5", "unqualified sequence gives no pulse", n_store - s0, 0);
      // interleaved RAM writes and idle gaps
      nvw(11'h555, 8'hAA, 2'd3);
      wr(1'b1, 11'h123, 8'h00, 2'd1);
      repeat (3) @(negedge clk);
      nvw(11'h2AA, 8'h55, 2'd3);
      wr(1'b1, 11'h555, 8'hCD, 2'd0);
      repeat (5) @(negedge clk);
      nvw(11'h555, 8'h33, 2'd3);
      settle();
      chk("R5", "interleaved RAM writes keep sequence", n_store - s0, 1);
      chk("R10", "idle gaps keep sequence / flag", int'(autostore_on), 1);
   endtask

   task automatic t_mismatch();
      int d0 = n_dis;
      nvw(11'h555, 8'hAA, 2'd0);
      nvw(11'h2AA, 8'h54, 2'd0);
      nvw(11'h2AA, 8'h55, 2'd0);
      nvw(11'h555, 8'hCD, 2'd0);
      settle();
      chk("R6", "wrong data aborts", n_dis - d0, 0);
      nvw(11'h555, 8'hAA, 2'd0);
      nvw(11'h2AA, 8'h55, 2'd0);
      nvw(11'h556, 8'hCD, 2'd0);
      nvw(11'h555, 8'hCD, 2'd0);
      settle();
      chk("R6", "wrong command address aborts", n_dis - d0, 0);
      chk("R6", "flag untouched after aborts", int'(autostore_on), 1);
   endtask

   task automatic t_restart();
      int d0 = n_dis, a0 = n_arm;
      nvw(11'h555, 8'hAA, 2'd0);
      nvw(11'h555, 8'hAA, 2'd0);
      nvw(11'h2AA, 8'h55, 2'd0);
      nvw(11'h555, 8'hCD, 2'd0);
      settle();
      chk("R7", "repeated first key restarts", n_dis - d0, 1);
      chk("R7", "flag after restarted disarm", int'(autostore_on), 0);
      // restart from second-step position with a new bank tag
      nvw(11'h555, 8'hAA, 2'd0);
      nvw(11'h2AA, 8'h55, 2'd0);
      nvw(11'h555, 8'hAA, 2'd1);
      nvw(11'h2AA, 8'h55, 2'd1);
      nvw(11'h555, 8'hCC, 2'd1);
      settle();
      chk("R7", "first key on new tag restarts", n_arm - a0, 1);
      chk("R9", "restarted sequence on new tag arms", int'(autostore_on), 1);
   endtask

   task automatic t_tag();
      int s0 = n_store;
      nvw(11'h555, 8'hAA, 2'd0);
      nvw(11'h2AA, 8'h55, 2'd1);
      nvw(11'h555, 8'h33, 2'd1);
      settle();
      chk("R9", "tag change at step two aborts", n_store - s0, 0);
      nvw(11'h555, 8'hAA, 2'd2);
      nvw(11'h2AA, 8'h55, 2'd2);
      nvw(11'h555, 8'h33, 2'd3);
      settle();
      chk("R9", "tag change at step three aborts", n_store - s0, 0);
   endtask

   task automatic t_unknown();
      int s0 = n_store, a0 = n_arm, d0 = n_dis;
      nvw(11'h555, 8'hAA, 2'd0);
      nvw(11'h2AA, 8'h55, 2'd0);
      nvw(11'h555, 8'h5A, 2'd0);
      chk("R8", "no pulse on unknown command", int'({store_req, arm_pulse, disarm_pulse}), 0);
      nvw(11'h555, 8'h33, 2'd0);
      settle();
      chk("R8", "detector idle after unknown command",
          (n_store - s0) + (n_arm - a0) + (n_dis - d0), 0);
      chk("R8", "flag unchanged by unknown command", int'(autostore_on), 1);
   endtask

   initial begin
      #4_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_store();
      t_disarm_arm();
      t_ram_writes();
      t_mismatch();
      t_restart();
      t_tag();
      t_unknown();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule